// File: doc/BRIEF.md
# Prioritized Interrupt Status-Word Swap Unit

This block takes interrupts for a processor whose entire 64-bit program status word is swapped through memory. Requests arrive from five classes. Each has its own request pulse and a 16-bit interrupt code, and each is latched into a pending slot. While the unit is idle it picks the highest-priority pending request that the current status word allows. It writes the current status word to that class's old-word slot in memory, with the interrupt code placed in the code field. It then reads the class's new-word slot and loads the result into the status register, which sends execution to the handler.

A handler returns through the load-status command. This command reads any doubleword in memory and loads it into the status register, which restores the interrupted state. All memory traffic uses one doubleword port. The unit raises a request and holds it until the memory acknowledges. Only one swap or load runs at a time.

Status word layout, shared with the unit's neighbours: bit 63 enables I/O interrupts and bit 62 enables external interrupts. Bits 57:54 are the program-exception mask, with bit 57 as mask bit 3. Bits 47:32 hold the interrupt code, and bits 23:0 hold the instruction address. Every other bit is carried through unchanged. Class numbers, from lowest to highest priority, are 0 I/O, 1 program exception, 2 supervisor call, 3 external and 4 machine check.

Top module: `psw_swap_unit`

## Requirements
- R1: While reset is asserted and after it is released, the status word is zero, busy is low and no memory request is raised until a request or load command arrives.
- R2: When several enabled requests are pending, the class with the highest number is taken first. Exactly one class is served per swap, and the rest stay pending for later swaps.
- R3: An I/O request is taken only while status bit 63 is set, and an external request only while status bit 62 is set. Blocked requests stay pending. Supervisor-call, program and machine-check requests are never gated by these bits.
- R4: A program request with cause 8, 10, 13 or 14 is discarded when the status mask bit 3, 2, 1 or 0 (status bits 57, 56, 55, 54) is clear at arrival. Every other cause is always latched. The cause is code bits 3:0, and only those bits are stored as the program interrupt code.
- R5: A swap for class c first writes the current status word, with bits 47:32 replaced by the class's code, to address OLD_BASE + 8c. It then reads NEW_BASE + 8c and loads the returned doubleword into the status register on the acknowledge.
- R6: A memory request stays asserted, with stable write flag, address and write data, until the cycle it is acknowledged.
- R7: A load-status command that arrives while the unit is idle reads the given address with its low three bits cleared and loads the result. Such a command wins over a pending interrupt in the same cycle. A command that arrives while the unit is busy is ignored.
- R8: Every load into the status register forces bit 0 to zero, so the instruction address is always halfword aligned.
- R9: Busy is high from the first memory request of a swap or load until the status register is loaded. No new swap starts while busy, and requests that arrive meanwhile are latched.
- R10: A repeated request for a class that is already pending replaces the stored code with the newest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | 5 | One-cycle request pulse per class |
| irq_code_i | input | 80 | 16-bit interrupt code per class, class c at bits 16c+15:16c |
| ldst_req_i | input | 1 | Load-status command pulse |
| ldst_addr_i | input | ADDR_W | Address of the doubleword for the load-status command |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | High for a write, low for a read |
| mem_addr_o | output | ADDR_W | Doubleword byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge, with read data valid in the same cycle |
| mem_rdata_i | input | 64 | Read data |
| psw_o | output | 64 | Current status word |
| busy_o | output | 1 | A swap or load is in progress |

## Verification
The bench builds the unit with ADDR_W of 24, OLD_BASE of 0x100 and NEW_BASE of 0x180. These bases are far from the defaults and far apart, so a wrong slot offset or a swapped old/new base lands on an address that holds no data and shows up at once. The bench's memory acknowledges after 0, 1 or 2 waiting cycles in rotation. This exercises back-to-back acknowledges, held requests and the one idle cycle between queued swaps. The status words that the bench loads set bit 0 and toggle the two enable bits, which exposes alignment, gating and priority behaviour.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;

  localparam int N_CLASS = 5;
  localparam int CLS_W   = 3;
  localparam int PSW_W   = 64;
  localparam int ICODE_W = 16;

  // status word field positions
  localparam int IOEN_BIT  = 63;
  localparam int EXTEN_BIT = 62;
  localparam int PMASK_HI  = 57;
  localparam int PMASK_LO  = 54;
  localparam int ICODE_HI  = 47;
  localparam int ICODE_LO  = 32;

  typedef enum logic [CLS_W-1:0] {
    CLS_IO   = 3'd0,
    CLS_PROG = 3'd1,
    CLS_SVC  = 3'd2,
    CLS_EXT  = 3'd3,
    CLS_MCHK = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WR_OLD = 2'd1,
    SQ_RD_NEW = 2'd2
  } seq_e;

  // program causes that the status mask may suppress
  function automatic logic cause_allowed(input logic [3:0] cause,
                                         input logic [3:0] pmask);
    logic ok;
    case (cause)
      4'd8:    ok = pmask[3];
      4'd10:   ok = pmask[2];
      4'd13:   ok = pmask[1];
      4'd14:   ok = pmask[0];
      default: ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/psw_pending.sv
module psw_pending
  import psw_swap_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CLASS-1:0]         req_i,
  input  logic [N_CLASS*ICODE_W-1:0] code_i,
  input  logic [3:0]                 pmask_i,
  input  logic [N_CLASS-1:0]         clr_i,
  output logic [N_CLASS-1:0]         pend_o,
  output logic [N_CLASS*ICODE_W-1:0] code_o
);

  for (genvar g = 0; g < N_CLASS; g++) begin : g_cls
    logic               accept;
    logic               pend_d;
    logic               pend_q;
    logic [ICODE_W-1:0] code_d;
    logic [ICODE_W-1:0] code_q;

    if (g == int'(CLS_PROG)) begin : g_prog
      // only the cause nibble is kept for program exceptions
      assign code_d = code_i[g*ICODE_W +: ICODE_W] & ICODE_W'(16'h000F);
      assign accept = req_i[g] && cause_allowed(code_d[3:0], pmask_i);
    end else begin : g_plain
      assign code_d = code_i[g*ICODE_W +: ICODE_W];
      assign accept = req_i[g];
    end

    // a new arrival wins over the clear of the swap being started
    assign pend_d = accept | (pend_q & ~clr_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= '0;
      else if (accept) code_q <= code_d;
    end

    assign pend_o[g]                     = pend_q;
    assign code_o[g*ICODE_W +: ICODE_W] = code_q;
  end

endmodule

// File: rtl/psw_arbiter.sv
module psw_arbiter
  import psw_swap_pkg::*;
(
  input  logic [N_CLASS-1:0] pend_i,
  input  logic               io_en_i,
  input  logic               ext_en_i,
  output logic               any_o,
  output logic [CLS_W-1:0]   cls_o
);

  logic [N_CLASS-1:0] elig;

  always_comb begin
    elig                 = pend_i;
    elig[int'(CLS_IO)]   = pend_i[int'(CLS_IO)]  & io_en_i;
    elig[int'(CLS_EXT)]  = pend_i[int'(CLS_EXT)] & ext_en_i;
  end

  // ascending scan: the last hit is the highest class number
  always_comb begin
    cls_o = '0;
    for (int i = 0; i < N_CLASS; i++) begin
      if (elig[i]) cls_o = CLS_W'(i);
    end
  end

  assign any_o = |elig;

endmodule

// File: rtl/psw_seq.sv
module psw_seq
  import psw_swap_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int OLD_BASE = 'h18,
  parameter int NEW_BASE = 'h58
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_i,
  input  logic [CLS_W-1:0]   cls_i,
  input  logic [ICODE_W-1:0] sel_code_i,
  input  logic               ldst_req_i,
  input  logic [ADDR_W-1:0]  ldst_addr_i,
  input  logic               mem_ack_i,
  input  logic [PSW_W-1:0]   mem_rdata_i,
  output logic [N_CLASS-1:0] clr_o,
  output logic [PSW_W-1:0]   psw_o,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [PSW_W-1:0]   mem_wdata_o
);

  localparam logic [ADDR_W-1:0] OLD_A = ADDR_W'(OLD_BASE);
  localparam logic [ADDR_W-1:0] NEW_A = ADDR_W'(NEW_BASE);

  function automatic logic [ADDR_W-1:0] slot_off(input logic [CLS_W-1:0] c);
    return ADDR_W'({c, 3'b000});
  endfunction

  seq_e               state_q, state_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [PSW_W-1:0]   wdata_q, wdata_d;
  logic [CLS_W-1:0]   cls_q, cls_d;
  logic [PSW_W-1:0]   psw_q, psw_d;
  logic               addr_en, wdata_en, cls_en, psw_en;
  logic [PSW_W-1:0]   merged;

  always_comb begin
    merged                    = psw_q;
    merged[ICODE_HI:ICODE_LO] = sel_code_i;
  end

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    cls_d    = cls_q;
    psw_d    = psw_q;
    addr_en  = 1'b0;
    wdata_en = 1'b0;
    cls_en   = 1'b0;
    psw_en   = 1'b0;
    clr_o    = '0;
    unique case (state_q)
      SQ_IDLE: begin
        if (ldst_req_i) begin
          state_d = SQ_RD_NEW;
          addr_en = 1'b1;
          addr_d  = {ldst_addr_i[ADDR_W-1:3], 3'b000};
        end else if (any_i) begin
          state_d  = SQ_WR_OLD;
          addr_en  = 1'b1;
          addr_d   = OLD_A + slot_off(cls_i);
          cls_en   = 1'b1;
          cls_d    = cls_i;
          wdata_en = 1'b1;
          wdata_d  = merged;
          clr_o    = N_CLASS'(1) << cls_i;
        end
      end
      SQ_WR_OLD: begin
        if (mem_ack_i) begin
          state_d = SQ_RD_NEW;
          addr_en = 1'b1;
          addr_d  = NEW_A + slot_off(cls_q);
        end
      end
      SQ_RD_NEW: begin
        if (mem_ack_i) begin
          state_d = SQ_IDLE;
          psw_en  = 1'b1;
          psw_d   = {mem_rdata_i[PSW_W-1:1], 1'b0};
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= wdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cls_q <= '0;
    else if (cls_en) cls_q <= cls_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psw_q <= '0;
    else if (psw_en) psw_q <= psw_d;
  end

  assign psw_o       = psw_q;
  assign busy_o      = (state_q != SQ_IDLE);
  assign mem_req_o   = (state_q != SQ_IDLE);
  assign mem_we_o    = (state_q == SQ_WR_OLD);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

endmodule

// File: rtl/psw_swap_unit.sv
module psw_swap_unit
  import psw_swap_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int OLD_BASE = 'h18,
  parameter int NEW_BASE = 'h58
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CLASS-1:0]         irq_req_i,
  input  logic [N_CLASS*ICODE_W-1:0] irq_code_i,
  input  logic                       ldst_req_i,
  input  logic [ADDR_W-1:0]          ldst_addr_i,
  output logic                       mem_req_o,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [PSW_W-1:0]           mem_wdata_o,
  input  logic                       mem_ack_i,
  input  logic [PSW_W-1:0]           mem_rdata_i,
  output logic [PSW_W-1:0]           psw_o,
  output logic                       busy_o
);

  logic                       rst_q_n;
  logic [N_CLASS-1:0]         pend;
  logic [N_CLASS*ICODE_W-1:0] code_flat;
  logic [N_CLASS-1:0]         clr;
  logic                       any;
  logic [CLS_W-1:0]           cls;
  logic [ICODE_W-1:0]         sel_code;
  logic [PSW_W-1:0]           psw;

  psw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  psw_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .req_i   (irq_req_i),
    .code_i  (irq_code_i),
    .pmask_i (psw[PMASK_HI:PMASK_LO]),
    .clr_i   (clr),
    .pend_o  (pend),
    .code_o  (code_flat)
  );

  psw_arbiter u_arb (
    .pend_i   (pend),
    .io_en_i  (psw[IOEN_BIT]),
    .ext_en_i (psw[EXTEN_BIT]),
    .any_o    (any),
    .cls_o    (cls)
  );

  always_comb begin
    sel_code = '0;
    for (int i = 0; i < N_CLASS; i++) begin
      if (cls == CLS_W'(i)) sel_code = code_flat[i*ICODE_W +: ICODE_W];
    end
  end

  psw_seq #(
    .ADDR_W   (ADDR_W),
    .OLD_BASE (OLD_BASE),
    .NEW_BASE (NEW_BASE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .any_i       (any),
    .cls_i       (cls),
    .sel_code_i  (sel_code),
    .ldst_req_i  (ldst_req_i),
    .ldst_addr_i (ldst_addr_i),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .clr_o       (clr),
    .psw_o       (psw),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign psw_o = psw;

endmodule

// File: rtl/psw_swap_chk.sv
module psw_swap_chk #(
  parameter int ADDR_W   = 24,
  parameter int OLD_BASE = 'h18,
  parameter int NEW_BASE = 'h58
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [63:0]       mem_wdata,
  input logic              mem_ack,
  input logic [63:0]       psw,
  input logic              busy
);

  localparam int OLD_END = OLD_BASE + 40;
  localparam int NEW_END = NEW_BASE + 40;

  // R6: request and its payload held until acknowledged
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R5: an acknowledged old-word write is followed by the new-word read
  a_r5_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

  // R5: writes only ever target an aligned old-word slot
  a_r5_write_in_old_slots: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (int'(mem_addr) >= OLD_BASE) && (int'(mem_addr) < OLD_END) && (mem_addr[2:0] == 3'b000));

  // R5: status register changes only on an acknowledged read
  a_r5_psw_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we && mem_ack) |=> $stable(psw));

  // R8: instruction address stays halfword aligned
  a_r8_even_address: assert property (@(posedge clk) disable iff (!rst_n)
    psw[0] == 1'b0);

  // R9: unit returns to idle right after the status load
  a_r9_idle_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> !busy);

  // R1: no memory traffic while idle
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // the new-slot window must not overlap the old-slot window
  initial begin
    a_r5_slots_disjoint: assert ((NEW_BASE >= OLD_END) || (OLD_BASE >= NEW_END));
  end

endmodule

bind psw_swap_unit psw_swap_chk #(
  .ADDR_W   (ADDR_W),
  .OLD_BASE (OLD_BASE),
  .NEW_BASE (NEW_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .mem_req   (mem_req_o),
  .mem_we    (mem_we_o),
  .mem_addr  (mem_addr_o),
  .mem_wdata (mem_wdata_o),
  .mem_ack   (mem_ack_i),
  .psw       (psw_o),
  .busy      (busy_o)
);

// File: tb/psw_swap_unit_tb_top.sv
module psw_swap_unit_tb_top;

  localparam int AW   = 24;
  localparam int OLDB = 'h100;
  localparam int NEWB = 'h180;

  logic          clk;
  logic          rst_n;
  logic [4:0]    irq_req;
  logic [79:0]   irq_code;
  logic          ldst_req;
  logic [AW-1:0] ldst_addr;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata, psw;
  logic          busy;

  psw_swap_unit #(.ADDR_W(AW), .OLD_BASE(OLDB), .NEW_BASE(NEWB)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_code_i(irq_code),
    .ldst_req_i(ldst_req), .ldst_addr_i(ldst_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .psw_o(psw), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory ----------------
  logic [63:0] mem [int];
  logic [AW:0] txq [$];
  int wcnt = 0;
  int lat  = 0;
  int ntx  = 0;

  function automatic logic [63:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] p, input logic [15:0] c);
    return (p & ~(64'hFFFF << 32)) | ({48'h0, c} << 32);
  endfunction

  function automatic logic [63:0] nw(input int i);
    return 64'hC000_0000_0000_0000 | 64'((i + 1) * 'h1000 + 1);
  endfunction

  localparam logic [63:0] RET_W = 64'hC3C0_0000_0000_2001;
  localparam logic [63:0] D_W   = 64'h8000_0000_0000_3001;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt    = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        else        mem_rdata = rd(int'(mem_addr));
        txq.push_back({mem_we, mem_addr});
        ntx++;
        lat = ntx % 3;
      end else begin
        wcnt++;
      end
    end
  end

  // ---------------- reference model ----------------
  int          m_st;
  int          m_cls;
  logic [63:0] m_psw, m_wd;
  logic [AW-1:0] m_addr;
  logic        m_pend [5];
  logic [15:0] m_code [5];
  bit          m_s0, m_s1;

  function automatic bit m_enabled(input int i, input logic [63:0] p);
    if (i == 0) return p[63];
    if (i == 3) return p[62];
    return 1'b1;
  endfunction

  function automatic bit m_accept(input int i, input logic [3:0] c, input logic [63:0] p);
    if (i != 1) return 1'b1;
    if (c == 8)  return p[57];
    if (c == 10) return p[56];
    if (c == 13) return p[55];
    if (c == 14) return p[54];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_st = 0; m_cls = 0; m_psw = '0; m_wd = '0; m_addr = '0;
      for (int i = 0; i < 5; i++) begin m_pend[i] = 0; m_code[i] = '0; end
    end else begin
      if (m_s1) begin
        automatic logic [63:0] p0 = m_psw;
        automatic int clr = -1;
        if (m_st == 0) begin
          if (ldst_req) begin
            m_st = 2; m_addr = ldst_addr & ~AW'(7);
          end else begin
            for (int i = 0; i < 5; i++)
              if (m_pend[i] && m_enabled(i, p0)) clr = i;
            if (clr >= 0) begin
              m_st = 1; m_cls = clr; m_addr = AW'(OLDB + 8 * clr);
              m_wd = merge(p0, m_code[clr]);
            end
          end
        end else if (m_st == 1) begin
          if (mem_ack) begin m_st = 2; m_addr = AW'(NEWB + 8 * m_cls); end
        end else begin
          if (mem_ack) begin m_st = 0; m_psw = mem_rdata & ~64'h1; end
        end
        for (int i = 0; i < 5; i++) begin
          automatic logic [15:0] ci = irq_code[i*16 +: 16];
          if (clr == i) m_pend[i] = 0;
          if (irq_req[i] && m_accept(i, ci[3:0], p0)) begin
            m_pend[i] = 1;
            m_code[i] = (i == 1) ? {12'h0, ci[3:0]} : ci;
          end
        end
      end
      m_s1 = m_s0;
      m_s0 = 1;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && m_s1 && !done) begin
      chk("R5 status word", psw, m_psw);
      chk("R9 busy", {63'h0, busy}, {63'h0, m_st != 0});
      if (m_st != 0)
        chk("R6 memory port", {mem_req, mem_we, mem_addr, mem_wdata},
            {1'b1, m_st == 1, m_addr, (m_st == 1) ? m_wd : mem_wdata});
      else
        chk("R6 memory port idle", {63'h0, mem_req}, 64'h0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_irq(input int c, input logic [15:0] code);
    @(negedge clk);
    irq_req[c] = 1'b1;
    irq_code[c*16 +: 16] = code;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic do_ldst(input logic [AW-1:0] a);
    @(negedge clk);
    ldst_req = 1'b1; ldst_addr = a;
    @(negedge clk);
    ldst_req = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int n = 0;
    while (quiet < 4 && n < 400) begin
      @(negedge clk);
      n++;
      if (busy) quiet = 0; else quiet++;
    end
    if (n >= 400) chk("R9 wait for idle", 64'h1, 64'h0);
  endtask

  task automatic count_busy(input int cycles, output int nb);
    nb = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (busy) nb++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R9 watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int nb;
    rst_n = 0; irq_req = '0; irq_code = '0; ldst_req = 0; ldst_addr = '0;
    mem_ack = 0; mem_rdata = '0;
    for (int i = 0; i < 5; i++) mem[NEWB + 8 * i] = nw(i);
    mem['h400] = RET_W;
    mem['h408] = D_W;
    repeat (3) @(negedge clk);
    chk("R1 reset status", psw, 64'h0);
    chk("R1 reset busy", {62'h0, busy, mem_req}, 64'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {psw[62:0], busy}, 64'h0);

    // R4 cause 8 dropped under zero mask; R3 io blocked with bit 63 clear
    pulse_irq(1, 16'h0008);
    pulse_irq(0, 16'h00A1);
    count_busy(10, nb);
    chk("R3 io blocked R4 cause dropped: busy cycles", 64'(nb), 64'h0);

    // R7 misaligned load-status, then pending io is served
    txq.delete();
    do_ldst(AW'('h403));
    wait_idle();
    chk("R7 first access is aligned read", 64'(txq[0]), 64'({1'b0, AW'('h400)}));
    chk("R7 R5 io old word holds loaded status", rd(OLDB), merge(RET_W & ~64'h1, 16'h00A1));
    chk("R8 status bit 0 cleared", psw, nw(0) & ~64'h1);
    chk("R4 masked cause never swapped", 64'(mem.exists(OLDB + 8)), 64'h0);

    // R2 all five at once
    txq.delete();
    @(negedge clk);
    irq_req = 5'b11111;
    irq_code = {16'h00C4, 16'h00C3, 16'h00C2, 16'hAB03, 16'h00C0};
    @(negedge clk);
    irq_req = '0;
    wait_idle();
    begin
      int w = 0;
      for (int k = 0; k < txq.size(); k++) begin
        if (txq[k][AW]) begin
          chk("R2 swap order", 64'(txq[k][AW-1:0]), 64'(OLDB + 8 * (4 - w)));
          w++;
        end
      end
      chk("R2 swap count", 64'(w), 64'd5);
    end
    chk("R5 machine-check old word", rd(OLDB + 32), merge(nw(0) & ~64'h1, 16'h00C4));
    chk("R5 external old word", rd(OLDB + 24), merge(nw(4) & ~64'h1, 16'h00C3));
    chk("R4 program code is cause only", rd(OLDB + 8), merge(nw(2) & ~64'h1, 16'h0003));
    chk("R2 final status", psw, nw(0) & ~64'h1);

    // R3 external gated, supervisor call not; R10 newest code kept
    do_ldst(AW'('h408));
    wait_idle();
    chk("R7 load-status value", psw, D_W & ~64'h1);
    pulse_irq(3, 16'h1111);
    pulse_irq(3, 16'h2222);
    count_busy(10, nb);
    chk("R3 external blocked by bit 62", 64'(nb), 64'h0);
    pulse_irq(2, 16'h0077);
    wait_idle();
    chk("R3 supervisor call taken", rd(OLDB + 16), merge(D_W & ~64'h1, 16'h0077));
    chk("R10 newest external code", rd(OLDB + 24), merge(nw(2) & ~64'h1, 16'h2222));

    // R7 ignored while busy; R9 request latched during swap
    pulse_irq(4, 16'h0044);
    while (!busy) @(negedge clk);
    @(negedge clk);
    ldst_req = 1'b1; ldst_addr = AW'('h408);
    irq_req[0] = 1'b1; irq_code[15:0] = 16'h0005;
    @(negedge clk);
    ldst_req = 1'b0; irq_req = '0;
    wait_idle();
    chk("R7 busy load ignored R9 latched io served", psw, nw(0) & ~64'h1);

    // R7 load-status wins over a pending machine check
    txq.delete();
    @(negedge clk);
    irq_req[4] = 1'b1; irq_code[79:64] = 16'h0099;
    @(negedge clk);
    irq_req = '0;
    ldst_req = 1'b1; ldst_addr = AW'('h400);
    @(negedge clk);
    ldst_req = 1'b0;
    wait_idle();
    chk("R7 load-status before interrupt", 64'(txq[0]), 64'({1'b0, AW'('h400)}));
    chk("R7 machine check after load", rd(OLDB + 32), merge(RET_W & ~64'h1, 16'h0099));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule